// File: doc/BRIEF.md
# Sequence-Armed Watchdog Timer

This block is a recovery watchdog for an 8-bit microcontroller. It sits on the special-function-register write port, which carries an address, a data byte and a one-clock write strobe. It comes out of reset switched off. Software arms it by writing a two-byte key to one register address. From then on, a counter advances once per machine cycle. Software must keep writing the same key pair to restart the counter before it runs out.

Once armed, software cannot switch the watchdog off. Only a hardware reset or the watchdog's own overflow returns it to the off state. When the counter runs past its top value, the block raises an active-high reset output for a fixed number of clocks. During that pulse the block clears itself, so one overflow gives exactly one pulse. The machine-cycle rate is supplied from outside as a one-clock tick strobe.

The write port is a plain strobe with no handshake. Every strobed write is taken in the clock it appears, so the port has no back-pressure.

Top module: `wdt_seq_top`

## Requirements
- R1: After reset the watchdog is disabled and `rst_out` is low. While disabled, no number of ticks produces a pulse.
- R2: Writing 0x1E and then 0xE1 to address 0xA6 arms the watchdog. The arming takes effect at the clock edge that takes the 0xE1 write, and the counter starts from zero.
- R3: While armed, the counter (CNT_W bits, 14 by default) advances by exactly one on each clock in which `cyc_tick` is high. It holds in clocks where `cyc_tick` is low.
- R4: The tick that arrives while the counter holds all ones (16383 by default) is an overflow. `rst_out` goes high at the next clock edge, so the pulse starts on the 2^CNT_W-th tick after arming or restart.
- R5: Writing the same key pair while armed sets the counter back to zero. If the 0xE1 write falls in the same clock as an overflowing tick, the restart wins and no pulse follows.
- R6: Software cannot disarm the watchdog or clear its count by any other write. Writing other values to 0xA6 leaves the watchdog armed and the count unchanged.
- R7: The reset pulse is high for exactly PULSE_LEN clocks (96 by default). Afterwards the watchdog is disabled with its counter at zero. Key writes made during the pulse have no effect.
- R8: A 0xE1 write arms or restarts the watchdog only when the previous write to 0xA6 was 0x1E. Any other value written to 0xA6 cancels a pending 0x1E, but a repeated 0x1E keeps it pending. Writes to any other address neither advance nor cancel the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| sfr_addr | input | 8 | Register address of the current write |
| sfr_wdata | input | 8 | Data byte of the current write |
| sfr_we | input | 1 | Write strobe, one clock per write |
| cyc_tick | input | 1 | Machine-cycle strobe, one clock wide |
| rst_out | output | 1 | Active-high reset pulse on overflow |

## Verification
A restart and an overflow can fall in the same clock. This happens when the 0xE1 key write arrives together with the tick that would carry an all-ones counter past its top. The bench provokes this case after exactly 2^CNT_W-1 ticks. It then judges that no pulse appears and that a full 2^CNT_W further ticks are needed before the next one. A second collision is a key write landing inside a running pulse. The bench judges that the pulse length is unchanged and that the block stays disabled afterwards.

// File: rtl/wdt_seq_pkg.sv
package wdt_seq_pkg;
  localparam int          DEF_CNT_W     = 14;
  localparam int          DEF_PULSE_LEN = 96;
  localparam logic [7:0]  DEF_SFR_ADDR  = 8'hA6;
  localparam logic [7:0]  DEF_KEY_A     = 8'h1E;
  localparam logic [7:0]  DEF_KEY_B     = 8'hE1;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_HALF = 1'b1
  } seq_state_e;
endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock
  import wdt_seq_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter int              DATA_W   = 8,
  parameter logic [ADDR_W-1:0] SFR_ADDR = DEF_SFR_ADDR,
  parameter logic [DATA_W-1:0] KEY_A    = DEF_KEY_A,
  parameter logic [DATA_W-1:0] KEY_B    = DEF_KEY_B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              key_hit
);
  seq_state_e state_q;
  logic       sel;

  assign sel = we && (addr == SFR_ADDR);

  // R8: only writes to the key address move the sequence
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
    end else if (flush) begin
      state_q <= SEQ_IDLE;
    end else if (sel) begin
      state_q <= (wdata == KEY_A) ? SEQ_HALF : SEQ_IDLE;
    end
  end

  assign key_hit = !flush && sel && (wdata == KEY_B) && (state_q == SEQ_HALF);
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             restart,
  input  logic             tick,
  output logic             en,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             en_q;
  logic [CNT_W-1:0] cnt_q;

  // R4/R5: the restart has priority over an overflowing tick
  assign wrap = en_q && tick && !restart && !flush && (cnt_q == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else if (flush) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else if (restart) begin
      en_q  <= 1'b1;
      cnt_q <= '0;
    end else if (en_q && tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign en  = en_q;
  assign cnt = cnt_q;
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int PULSE_LEN = 96
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active
);
  localparam int PW = $clog2(PULSE_LEN + 1);
  localparam logic [PW-1:0] LOAD = PW'(PULSE_LEN);

  logic [PW-1:0] rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (fire) begin
      rem_q <= LOAD;
    end else if (rem_q != '0) begin
      rem_q <= rem_q - 1'b1;
    end
  end

  assign active = (rem_q != '0);
endmodule

// File: rtl/wdt_seq_top.sv
module wdt_seq_top
  import wdt_seq_pkg::*;
#(
  parameter int         CNT_W     = DEF_CNT_W,
  parameter int         PULSE_LEN = DEF_PULSE_LEN,
  parameter logic [7:0] SFR_ADDR  = DEF_SFR_ADDR,
  parameter logic [7:0] KEY_A     = DEF_KEY_A,
  parameter logic [7:0] KEY_B     = DEF_KEY_B
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] sfr_addr,
  input  logic [7:0] sfr_wdata,
  input  logic       sfr_we,
  input  logic       cyc_tick,
  output logic       rst_out
);
  logic             key_hit;
  logic             wd_en;
  logic [CNT_W-1:0] wd_cnt;
  logic             wd_wrap;
  logic             pulse_on;

  wdt_unlock #(
    .ADDR_W(8), .DATA_W(8),
    .SFR_ADDR(SFR_ADDR), .KEY_A(KEY_A), .KEY_B(KEY_B)
  ) u_unlock (
    .clk(clk), .rst_n(rst_n), .flush(pulse_on),
    .we(sfr_we), .addr(sfr_addr), .wdata(sfr_wdata),
    .key_hit(key_hit)
  );

  wdt_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .flush(pulse_on),
    .restart(key_hit), .tick(cyc_tick),
    .en(wd_en), .cnt(wd_cnt), .wrap(wd_wrap)
  );

  wdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(wd_wrap), .active(pulse_on)
  );

  assign rst_out = pulse_on;
endmodule

// File: rtl/wdt_seq_chk.sv
module wdt_seq_chk #(
  parameter int CNT_W     = 14,
  parameter int PULSE_LEN = 96
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             rst_out,
  input logic             en,
  input logic [CNT_W-1:0] cnt,
  input logic             hit
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [31:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_q <= '0;
    else if (rst_out) run_q <= run_q + 1'b1;
    else              run_q <= '0;
  end

  a_r1_stay_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !hit) |=> !en);
  a_r2_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !rst_out) |=> (en && cnt == '0));
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick && !hit && !rst_out) |=> $stable(cnt));
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !hit && !rst_out && cnt != CNT_MAX) |=>
      (cnt == CNT_W'($past(cnt) + 1'b1)));
  a_r4_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out) |-> ($past(en) && $past(tick) && $past(cnt) == CNT_MAX && !$past(hit)));
  a_r6_no_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !rst_out) |=> en);
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out |=> (!en && cnt == '0));
  a_r7_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out) |-> (run_q == 32'(PULSE_LEN)));
endmodule

bind wdt_seq_top wdt_seq_chk #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(cyc_tick), .rst_out(rst_out),
  .en(wd_en), .cnt(wd_cnt), .hit(key_hit)
);

// File: tb/wdt_seq_top_test.sv
module wdt_seq_top_test;
  localparam int CW = 5;
  localparam int PL = 7;
  localparam int NT = 1 << CW;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] sfr_addr = 8'h00;
  logic [7:0] sfr_wdata = 8'h00;
  logic       sfr_we = 1'b0;
  logic       cyc_tick = 1'b0;
  logic       rst_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wdt_seq_top #(.CNT_W(CW), .PULSE_LEN(PL)) uut (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .sfr_we(sfr_we), .cyc_tick(cyc_tick), .rst_out(rst_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input bit t = 1'b0);
    sfr_we = 1'b1; sfr_addr = a; sfr_wdata = d; cyc_tick = t;
    @(negedge clk);
    sfr_we = 1'b0; cyc_tick = 1'b0;
  endtask

  task automatic arm();
    wr(8'hA6, 8'h1E);
    wr(8'hA6, 8'hE1);
  endtask

  // issues n ticks with gap idle clocks; returns tick index at which rst_out rose, 0 if none
  task automatic ticks(input int n, input int gap, output int hit_at);
    hit_at = 0;
    for (int i = 1; i <= n; i++) begin
      cyc_tick = 1'b1;
      @(negedge clk);
      cyc_tick = 1'b0;
      if (rst_out) begin hit_at = i; break; end
      repeat (gap) @(negedge clk);
      if (rst_out) begin hit_at = -i; break; end
    end
  endtask

  task automatic pulse_width(output int w);
    w = 0;
    while (rst_out) begin w++; @(negedge clk); end
  endtask

  initial begin
    int h;
    int w;
    repeat (3) @(negedge clk);
    check(rst_out == 1'b0, "R1 reset output", int'(rst_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    ticks(NT + 4, 0, h);
    check(h == 0, "R1 disabled ignores ticks", h, 0);

    // R2 R4 R5 R7: restart sweep over every service point
    for (int s = 0; s < NT; s++) begin
      arm();
      ticks(s, 0, h);
      check(h == 0, "R5 no early pulse", h, 0);
      arm();
      ticks(NT + 2, 0, h);
      check(h == NT, "R4 pulse after full count", h, NT);
      pulse_width(w);
      check(w == PL, "R7 pulse length", w, PL);
    end

    // R3: sparse ticks still need exactly NT ticks
    arm();
    ticks(NT + 2, 2, h);
    check(h == NT, "R3 sparse ticks", h, NT);
    pulse_width(w);
    check(w == PL, "R7 pulse length sparse", w, PL);

    // R7: disabled after pulse
    ticks(NT + 4, 0, h);
    check(h == 0, "R7 disabled after pulse", h, 0);

    // R6: other values to key address do not disarm or clear
    arm();
    ticks(10, 0, h);
    wr(8'hA6, 8'h00);
    wr(8'hA6, 8'h1E);
    wr(8'hA6, 8'h55);
    ticks(NT + 2, 0, h);
    check(h == NT - 10, "R6 no disarm no clear", h, NT - 10);
    pulse_width(w);

    // R8: cancelled sequence does not arm
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'h55); wr(8'hA6, 8'hE1);
    ticks(NT + 4, 0, h);
    check(h == 0, "R8 cancelled key", h, 0);
    wr(8'hA6, 8'hE1);
    ticks(NT + 4, 0, h);
    check(h == 0, "R8 lone second key", h, 0);
    // R8: other address in between keeps sequence
    wr(8'hA6, 8'h1E); wr(8'h80, 8'h55); wr(8'h81, 8'hE1); wr(8'hA6, 8'hE1);
    ticks(NT + 2, 0, h);
    check(h == NT, "R8 other address transparent", h, NT);
    pulse_width(w);
    // R8: repeated first key stays pending
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
    ticks(NT + 2, 0, h);
    check(h == NT, "R8 repeated first key", h, NT);
    pulse_width(w);

    // R5: restart coincides with overflowing tick
    arm();
    ticks(NT - 1, 0, h);
    wr(8'hA6, 8'h1E);
    wr(8'hA6, 8'hE1, 1'b1);
    check(rst_out == 1'b0, "R5 restart beats overflow", int'(rst_out), 0);
    ticks(NT + 2, 0, h);
    check(h == NT, "R5 full count after collision", h, NT);

    // R7: key writes during pulse ignored
    wr(8'hA6, 8'h1E);
    wr(8'hA6, 8'hE1);
    pulse_width(w);
    check(w == PL - 2, "R7 pulse unaffected by writes", w, PL - 2);
    ticks(NT + 4, 0, h);
    check(h == 0, "R7 writes in pulse ignored", h, 0);

    // R1: hardware reset disarms
    arm();
    ticks(5, 0, h);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    ticks(NT + 4, 0, h);
    check(h == 0, "R1 reset disarms", h, 0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule